// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This unit sits between a timer's event outputs and the CPU's interrupt logic. Each timer event pulse (channel 0 compare, channel 1 compare, counter overflow) sets its own sticky status flag. The flag is set whether or not that source is masked. Software clears a flag by writing a 0 to its bit.

Per-source mask bits select which set flags may raise the CPU-level pending flag. A global timer enable then gates the interrupt request. The request is formed from the level of flags AND masks. It is not formed from event edges. So when a mask bit is raised while its flag is already set, a request appears on the next cycle with no new event. The pending flag is sticky and software clears it. If a masked-in flag is still set, the pending flag sets again on the following cycle.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset, `flags_o`, `cpu_pend_o` and `irq_o` are all zero.
- R2: A 1 on `ev_i[k]` at a clock edge sets `flags_o[k]` from that edge on, whatever `mask_i[k]` is. Bit order: 0 = channel 0 compare, 1 = channel 1 compare, 2 = overflow.
- R3: Flags are sticky. On an edge where `flag_wr_en_i` is 1, each bit with `flag_wr_data_i[k]` = 0 is cleared. Each bit written with 1 keeps its value, and a 1 never sets a flag.
- R4: If an event and a clear of the same flag meet at one edge, the flag ends up set.
- R5: `cpu_pend_o` rises one cycle after some flag is set with its mask bit at 1. It does not rise from flags whose mask bit is 0.
- R6: `pend_clr_i` clears `cpu_pend_o` at that edge. If a masked-in flag remains set, `cpu_pend_o` is 1 again one cycle later.
- R7: `irq_o` is a registered level. It is 1 one cycle after some flag and its mask are both 1 while `gie_i` is 1. It stays 0 while `gie_i` is 0.
- R8: Raising `mask_i[k]` while `flags_o[k]` is already set, with `gie_i` at 1, raises `irq_o` one cycle later with no new event.
- R9: `irq_o` falls one cycle after the last enabled flag is cleared or `gie_i` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | NSRC | Event pulses: bit 0 ch0 compare, bit 1 ch1 compare, bit 2 overflow |
| flag_wr_en_i | input | 1 | Write strobe for the flag register |
| flag_wr_data_i | input | NSRC | Write data: 0 clears the bit, 1 leaves it |
| mask_i | input | NSRC | Per-source mask bits |
| gie_i | input | 1 | Global timer interrupt enable |
| pend_clr_i | input | 1 | Clears the CPU pending flag |
| flags_o | output | NSRC | Sticky source flags |
| cpu_pend_o | output | 1 | CPU-level pending flag |
| irq_o | output | 1 | Interrupt request level |

## Verification
A flag register that has lost a bit shows up at once on `flags_o`. One cycle later it shows as a missing `cpu_pend_o` or `irq_o` for a masked-in source. A flag held stuck shows as a request that fails to drop one cycle after the clearing write. A request logic wrongly driven by edges shows only in the late-mask case: `irq_o` stays low in the cycle after the mask rises, where the bench expects a 1. The event-against-clear race is visible on the edge it occurs.

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_i,
  input  logic            flag_wr_en_i,
  input  logic [NSRC-1:0] flag_wr_data_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            gie_i,
  input  logic            pend_clr_i,
  output logic [NSRC-1:0] flags_o,
  output logic            cpu_pend_o,
  output logic            irq_o
);

  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] clr_mask;
  logic            masked_any;
  logic            pend_q;
  logic            irq_q;

  assign clr_mask   = flag_wr_en_i ? ~flag_wr_data_i : '0;
  assign masked_any = |(flag_q & mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_mask) | ev_i;
      pend_q <= pend_clr_i ? 1'b0 : (pend_q | masked_any);
      irq_q  <= masked_any & gie_i;
    end
  end

  assign flags_o    = flag_q;
  assign cpu_pend_o = pend_q;
  assign irq_o      = irq_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    p_ev_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[k] |=> flags_o[k]);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[k] && !(flag_wr_en_i && !flag_wr_data_i[k])) |=> flags_o[k]);
    p_race_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[k] && flag_wr_en_i && !flag_wr_data_i[k]) |=> flags_o[k]);
  end

  p_pend_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_pend_o) |-> $past(|(flags_o & mask_i)));
  p_pend_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_i |=> !cpu_pend_o);
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gie_i && |(flags_o & mask_i)));
  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && |(flags_o & mask_i)) |=> irq_o);
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gie_i && |(flags_o & mask_i)) |=> !irq_o);

endmodule

// File: tb/timer_irq_flags_bench.sv
module timer_irq_flags_bench;
  localparam int NSRC = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] ev_i;
  logic            flag_wr_en_i;
  logic [NSRC-1:0] flag_wr_data_i;
  logic [NSRC-1:0] mask_i;
  logic            gie_i;
  logic            pend_clr_i;
  logic [NSRC-1:0] flags_o;
  logic            cpu_pend_o;
  logic            irq_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  timer_irq_flags #(.NSRC(NSRC)) u_timer_irq_flags (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .flag_wr_en_i(flag_wr_en_i),
    .flag_wr_data_i(flag_wr_data_i), .mask_i(mask_i), .gie_i(gie_i),
    .pend_clr_i(pend_clr_i), .flags_o(flags_o), .cpu_pend_o(cpu_pend_o),
    .irq_o(irq_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    ev_i = '0; mask_i = '0; gie_i = 1'b0;
    flag_wr_en_i = 1'b1; flag_wr_data_i = '0; pend_clr_i = 1'b1;
    step();
    flag_wr_en_i = 1'b0; flag_wr_data_i = '1; pend_clr_i = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ev_i = '0; flag_wr_en_i = 1'b0; flag_wr_data_i = '1;
    mask_i = '1; gie_i = 1'b1; pend_clr_i = 1'b0;
    repeat (3) step();
    chk("R1 flags", {1'b0, flags_o}, 4'h0);
    chk("R1 pend", {3'b0, cpu_pend_o}, 4'h0);
    chk("R1 irq", {3'b0, irq_o}, 4'h0);
    rst_n = 1'b1;
    clear_all();
  endtask

  task automatic t_unmasked();
    clear_all();
    gie_i = 1'b1;
    ev_i = 3'b101; step(); ev_i = '0;
    chk("R2 flags set while unmasked", {1'b0, flags_o}, 4'h5);
    step();
    chk("R5 no pend from unmasked", {3'b0, cpu_pend_o}, 4'h0);
    chk("R7 no irq from unmasked", {3'b0, irq_o}, 4'h0);
    ev_i = 3'b010; step(); ev_i = '0;
    chk("R2 ch1 flag", {1'b0, flags_o}, 4'h7);
  endtask

  task automatic t_clear();
    clear_all();
    ev_i = 3'b111; step(); ev_i = '0;
    flag_wr_en_i = 1'b1; flag_wr_data_i = 3'b101; step(); flag_wr_en_i = 1'b0;
    chk("R3 write 0 clears bit 1 only", {1'b0, flags_o}, 4'h5);
    flag_wr_en_i = 1'b1; flag_wr_data_i = 3'b111; step(); flag_wr_en_i = 1'b0;
    chk("R3 write 1 keeps", {1'b0, flags_o}, 4'h5);
    flag_wr_en_i = 1'b1; flag_wr_data_i = 3'b011; step(); flag_wr_en_i = 1'b0;
    chk("R3 clear overflow", {1'b0, flags_o}, 4'h1);
    step();
    chk("R3 sticky", {1'b0, flags_o}, 4'h1);
  endtask

  task automatic t_race();
    clear_all();
    ev_i = 3'b001; flag_wr_en_i = 1'b1; flag_wr_data_i = 3'b000; step();
    ev_i = '0; flag_wr_en_i = 1'b0;
    chk("R4 event beats clear", {1'b0, flags_o}, 4'h1);
  endtask

  task automatic t_pend();
    clear_all();
    mask_i = 3'b100;
    ev_i = 3'b100; step(); ev_i = '0;
    chk("R5 pend not yet", {3'b0, cpu_pend_o}, 4'h0);
    step();
    chk("R5 pend rises", {3'b0, cpu_pend_o}, 4'h1);
    chk("R7 irq low without gie", {3'b0, irq_o}, 4'h0);
    pend_clr_i = 1'b1; step(); pend_clr_i = 1'b0;
    chk("R6 pend cleared", {3'b0, cpu_pend_o}, 4'h0);
    step();
    chk("R6 pend re-set", {3'b0, cpu_pend_o}, 4'h1);
    flag_wr_en_i = 1'b1; flag_wr_data_i = 3'b011; step(); flag_wr_en_i = 1'b0;
    pend_clr_i = 1'b1; step(); pend_clr_i = 1'b0;
    step();
    chk("R6 pend stays clear", {3'b0, cpu_pend_o}, 4'h0);
  endtask

  task automatic t_irq();
    clear_all();
    gie_i = 1'b1; mask_i = 3'b001;
    ev_i = 3'b001; step(); ev_i = '0;
    chk("R7 irq not yet", {3'b0, irq_o}, 4'h0);
    step();
    chk("R7 irq high", {3'b0, irq_o}, 4'h1);
    gie_i = 1'b0; step();
    chk("R9 irq drops on gie", {3'b0, irq_o}, 4'h0);
    gie_i = 1'b1; step();
    chk("R7 irq back", {3'b0, irq_o}, 4'h1);
    flag_wr_en_i = 1'b1; flag_wr_data_i = 3'b110; step(); flag_wr_en_i = 1'b0;
    chk("R9 irq one cycle late", {3'b0, irq_o}, 4'h1);
    step();
    chk("R9 irq drops on clear", {3'b0, irq_o}, 4'h0);
  endtask

  task automatic t_late_mask();
    clear_all();
    gie_i = 1'b1;
    ev_i = 3'b010; step(); ev_i = '0;
    step(); step();
    chk("R8 no irq while masked", {3'b0, irq_o}, 4'h0);
    mask_i = 3'b010; step();
    chk("R8 irq on late mask", {3'b0, irq_o}, 4'h1);
    chk("R8 pend on late mask", {3'b0, cpu_pend_o}, 4'h1);
    mask_i = 3'b000; step();
    chk("R9 irq drops on unmask", {3'b0, irq_o}, 4'h0);
  endtask

  initial begin
    t_reset();
    t_unmasked();
    t_clear();
    t_race();
    t_pend();
    t_irq();
    t_late_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule